// File: doc/BRIEF.md
# Successive-Approximation Conversion and Calibration Sequencer

This block is the digital control core of a 16-bit charge-redistribution converter. It runs in a fast system clock domain and sees the slow conversion clock as a one-cycle strobe, `conv_tick`, that marks each rising edge of the conversion clock. A falling edge on `sample` starts a conversion and `busy` goes high. The block then runs a binary search, one bit per tick. It drives the trial word to the DAC and reads a 1-bit comparator decision at each tick. On the seventeenth tick it latches a two's complement result and drops `busy`.

The `cal` input is an asynchronous reset. While it is high the block is cleared and `busy` is held high. When `cal` is released, a fixed calibration program runs. The program has ten equal steps. The first step nulls the sample-hold offset against the ground-sense input. The other nine steps measure the weights of the nine most significant bits, from the top bit down. At the end of each step the block stores the correction word from the analog side into a ten-entry trim file. During conversions the trim file feeds `trim_word`, so the analog side can apply each bit's correction while that bit is under trial.

Top module: `sar_cal_seq`

## Requirements
- R1: While `cal` is high, `busy` is 1, `result` is 0x0000 and `cal_step` is 0, without waiting for a clock edge. This applies during a conversion too, which is then abandoned.
- R2: After `cal` falls, `busy` stays high for exactly 85,530 ticks and falls on the clock edge of the 85,530th tick. `cal_step` is tick_count / 8553 while the program runs and 0 once it ends.
- R3: At the last tick of step s (s = 0 to 9), the value on `cal_meas` is stored as trim entry s. Entry 0 is the offset and entry k is the correction for bit 16-k.
- R4: With `busy` low, a 1-to-0 change of `sample` seen at one clock edge sets `busy` on that edge, and `dac_word` becomes 0x8000.
- R5: At conversion tick k (1 to 16), bit 16-k of the trial word is kept if `comp` is 1 and cleared if it is 0, and the next lower bit is set. The result is written, and `busy` falls, on the 17th tick, and not before.
- R6: `result` equals the final trial word with bit 15 inverted (two's complement). An input above full scale gives 0x7FFF and one below negative full scale gives 0x8000.
- R7: Changes of `sample`, falling edges included, have no effect while `busy` is high.
- R8: While `busy` is low, ticks do not change `result` or `dac_word`.
- R9: If `sample` is already high when `busy` falls, its next falling edge starts a new conversion with no further setup.
- R10: While the calibration program runs and `sample` is high, `result[1:0]` shows `cal_step[1:0]`. With `sample` low, `result` keeps its held value.
- R11: After calibration, one tick while idle is needed. If a conversion starts before that tick, its first tick only absorbs the missing tick. The MSB decision is then skipped and bit 15 of the trial word stays 1.
- R12: During a conversion, after k ticks, `trim_word` is entry k+1 for k = 0 to 8. Otherwise it is entry 0.
- R13: Raising `cal` during calibration restarts the program from step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cal | input | 1 | Asynchronous reset that starts calibration, active high |
| sample | input | 1 | Acquire when high; a falling edge commits a conversion |
| conv_tick | input | 1 | One-cycle strobe for each conversion clock rising edge |
| comp | input | 1 | Comparator decision: 1 means the input is at or above the trial level |
| cal_meas | input | 16 | Correction word measured by the analog side for the current step |
| busy | output | 1 | High during conversion and calibration |
| dac_word | output | 16 | Trial word, in offset binary |
| result | output | 16 | Held two's complement result (diagnostic bits during calibration) |
| cal_step | output | 4 | Index of the current calibration step |
| trim_word | output | 16 | Trim entry for the bit under trial |

## Verification
`busy` rises on the first clock edge after `sample` is seen low, following a high sample. Each bit decision is taken on the edge that carries a tick. The result and the fall of `busy` belong to the edge of the 17th tick, and the end of calibration to the edge of the 85,530th tick. The bench drives inputs on falling clock edges and counts every tick it issues. It samples outputs at the falling edge after the counted edge. It checks `busy` and the old result after the 16th tick and the new values after the 17th, and checks the calibration step one tick on each side of a step boundary. The `cal` effects are asynchronous, so they are checked 1 ns after `cal` changes, before the next edge.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
   typedef enum logic [1:0] {
      ST_CAL  = 2'd0,
      ST_IDLE = 2'd1,
      ST_CONV = 2'd2
   } seq_state_t;
endpackage

// File: rtl/sar_bit_engine.sv
`timescale 1ns/1ps
// Binary-search engine: one trial bit resolved per enabled step.
module sar_bit_engine #(
   parameter int DW = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     start,
   input  logic                     step_en,
   input  logic                     skip_msb,
   input  logic                     comp,
   output logic [DW-1:0]            trial,
   output logic [$clog2(DW+1)-1:0]  cnt,
   output logic                     last
);
   localparam int CW = $clog2(DW+1);

   generate
      if (DW < 3) begin : g_bad_dw
         $error("sar_bit_engine: DW must be at least 3");
      end
   endgenerate

   logic [CW-1:0] cnt_q;
   logic          adv;

   assign last = (cnt_q == CW'(DW));
   assign adv  = step_en & ~last;
   assign cnt  = cnt_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst)        cnt_q <= '0;
      else if (start) cnt_q <= '0;
      else if (adv)   cnt_q <= cnt_q + CW'(1);
   end

   // each bit owns its register; decision on its own step, set one step earlier
   generate
      for (genvar i = 0; i < DW; i++) begin : g_bit
         localparam int CUR = DW - 1 - i;
         logic bit_q;
         if (i == DW - 1) begin : g_msb
            always_ff @(posedge clk or posedge rst) begin
               if (rst)        bit_q <= 1'b0;
               else if (start) bit_q <= 1'b1;
               else if (adv && cnt_q == CW'(CUR)) bit_q <= comp | skip_msb;
            end
         end else begin : g_low
            always_ff @(posedge clk or posedge rst) begin
               if (rst)        bit_q <= 1'b0;
               else if (start) bit_q <= 1'b0;
               else if (adv) begin
                  if (cnt_q == CW'(CUR))          bit_q <= comp;
                  else if (cnt_q == CW'(CUR - 1)) bit_q <= 1'b1;
               end
            end
         end
         assign trial[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/sar_cal_stepper.sv
`timescale 1ns/1ps
// Calibration program: N_CORR equal steps spanning CAL_TICKS ticks.
module sar_cal_stepper #(
   parameter int CAL_TICKS = 85530,
   parameter int N_CORR    = 10
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        run,
   output logic [$clog2(N_CORR)-1:0]   step,
   output logic                        wr_en,
   output logic                        done
);
   localparam int STEP_LEN = CAL_TICKS / N_CORR;
   localparam int LW       = (STEP_LEN > 1) ? $clog2(STEP_LEN) : 1;
   localparam int SW       = $clog2(N_CORR);

   generate
      if (N_CORR < 4) begin : g_bad_steps
         $error("sar_cal_stepper: N_CORR must be at least 4");
      end
      if (CAL_TICKS % N_CORR != 0) begin : g_bad_len
         $error("sar_cal_stepper: CAL_TICKS must divide evenly into N_CORR steps");
      end
      if (STEP_LEN < 2) begin : g_bad_step_len
         $error("sar_cal_stepper: each step needs at least two ticks");
      end
   endgenerate

   logic [LW-1:0] within_q;
   logic [SW-1:0] step_q;
   logic          step_end;

   assign step_end = (within_q == LW'(STEP_LEN - 1));
   assign wr_en    = run & step_end;
   assign done     = wr_en & (step_q == SW'(N_CORR - 1));
   assign step     = step_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         within_q <= '0;
         step_q   <= '0;
      end else if (run) begin
         if (step_end) begin
            within_q <= '0;
            step_q   <= done ? '0 : step_q + SW'(1);
         end else begin
            within_q <= within_q + LW'(1);
         end
      end
   end
endmodule

// File: rtl/sar_trim_file.sv
`timescale 1ns/1ps
// Register file of correction words, cleared by the calibration reset.
module sar_trim_file #(
   parameter int N_CORR = 10,
   parameter int TW     = 16
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [$clog2(N_CORR)-1:0]   wr_idx,
   input  logic [TW-1:0]               wr_data,
   input  logic [$clog2(N_CORR)-1:0]   rd_idx,
   output logic [TW-1:0]               rd_data
);
   localparam int IW = $clog2(N_CORR);

   logic [TW-1:0] ent [N_CORR];

   generate
      for (genvar e = 0; e < N_CORR; e++) begin : g_ent
         logic [TW-1:0] word_q;
         always_ff @(posedge clk or posedge rst) begin
            if (rst)                               word_q <= '0;
            else if (wr_en && wr_idx == IW'(e))    word_q <= wr_data;
         end
         assign ent[e] = word_q;
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      for (int e = 0; e < N_CORR; e++) begin
         if (rd_idx == IW'(e)) rd_data = ent[e];
      end
   end
endmodule

// File: rtl/sar_cal_seq.sv
`timescale 1ns/1ps
// Conversion / calibration sequencer top.
module sar_cal_seq
   import sar_seq_pkg::*;
#(
   parameter int DW        = 16,
   parameter int TW        = 16,
   parameter int CAL_TICKS = 85530,
   parameter int N_CORR    = 10
) (
   input  logic                        clk,
   input  logic                        cal,
   input  logic                        sample,
   input  logic                        conv_tick,
   input  logic                        comp,
   input  logic [TW-1:0]               cal_meas,
   output logic                        busy,
   output logic [DW-1:0]               dac_word,
   output logic [DW-1:0]               result,
   output logic [$clog2(N_CORR)-1:0]   cal_step,
   output logic [TW-1:0]               trim_word
);
   localparam int CW = $clog2(DW+1);
   localparam int SW = $clog2(N_CORR);
   localparam logic [DW-1:0] SIGN = {1'b1, {(DW-1){1'b0}}};

   generate
      if (N_CORR - 1 > DW) begin : g_bad_corr
         $error("sar_cal_seq: more bit corrections than bits");
      end
      if (SW < 2) begin : g_bad_diag
         $error("sar_cal_seq: step index too narrow for the diagnostic bits");
      end
   endgenerate

   seq_state_t     state_q;
   logic           busy_q, sample_q, tail_q;
   logic [DW-1:0]  res_q;
   logic [DW-1:0]  eng_trial;
   logic [CW-1:0]  eng_cnt;
   logic           eng_last;
   logic [SW-1:0]  step;
   logic           cal_wr, cal_done;
   logic [SW-1:0]  rd_idx;
   logic           in_conv, in_cal, commit, finish;

   assign in_conv = (state_q == ST_CONV);
   assign in_cal  = (state_q == ST_CAL);
   assign commit  = (state_q == ST_IDLE) & sample_q & ~sample;
   assign finish  = in_conv & conv_tick & eng_last;

   sar_bit_engine #(.DW(DW)) i_engine (
      .clk      (clk),
      .rst      (cal),
      .start    (commit),
      .step_en  (in_conv & conv_tick),
      .skip_msb (tail_q),
      .comp     (comp),
      .trial    (eng_trial),
      .cnt      (eng_cnt),
      .last     (eng_last)
   );

   sar_cal_stepper #(.CAL_TICKS(CAL_TICKS), .N_CORR(N_CORR)) i_stepper (
      .clk   (clk),
      .rst   (cal),
      .run   (in_cal & conv_tick),
      .step  (step),
      .wr_en (cal_wr),
      .done  (cal_done)
   );

   always_comb begin
      if (in_conv && eng_cnt < CW'(N_CORR - 1)) rd_idx = SW'(eng_cnt) + SW'(1);
      else                                      rd_idx = '0;
   end

   sar_trim_file #(.N_CORR(N_CORR), .TW(TW)) i_trim (
      .clk     (clk),
      .rst     (cal),
      .wr_en   (cal_wr),
      .wr_idx  (step),
      .wr_data (cal_meas),
      .rd_idx  (rd_idx),
      .rd_data (trim_word)
   );

   always_ff @(posedge clk or posedge cal) begin
      if (cal) begin
         state_q  <= ST_CAL;
         busy_q   <= 1'b1;
         res_q    <= '0;
         sample_q <= 1'b0;
         tail_q   <= 1'b0;
      end else begin
         sample_q <= sample;
         unique case (state_q)
            ST_CAL: begin
               if (cal_done) begin
                  state_q <= ST_IDLE;
                  busy_q  <= 1'b0;
                  tail_q  <= 1'b1;
               end
            end
            ST_IDLE: begin
               if (commit) begin
                  state_q <= ST_CONV;
                  busy_q  <= 1'b1;
               end else if (conv_tick) begin
                  tail_q  <= 1'b0;
               end
            end
            ST_CONV: begin
               if (conv_tick) tail_q <= 1'b0;
               if (finish) begin
                  res_q   <= eng_trial ^ SIGN;
                  busy_q  <= 1'b0;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_CAL;
         endcase
      end
   end

   assign busy     = busy_q;
   assign dac_word = eng_trial;
   assign cal_step = step;
   assign result   = (in_cal && sample) ? {res_q[DW-1:2], step[1:0]} : res_q;
endmodule

// File: rtl/sar_cal_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker, attached to every sar_cal_seq instance.
module sar_cal_seq_chk #(
   parameter int DW     = 16,
   parameter int N_CORR = 10
) (
   input logic                        clk,
   input logic                        cal,
   input logic                        sample,
   input logic                        conv_tick,
   input logic                        busy,
   input logic [DW-1:0]               dac_word,
   input logic [DW-1:0]               result,
   input logic [$clog2(N_CORR)-1:0]   cal_step
);
   localparam int SW = $clog2(N_CORR);
   localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

   assert_commit_R4: assert property (@(posedge clk) disable iff (cal)
      ($fell(sample) && !busy) |=> busy);

   assert_conv_start_R4: assert property (@(posedge clk) disable iff (cal)
      $rose(busy) |-> (dac_word == MID));

   assert_busy_hold_R5: assert property (@(posedge clk) disable iff (cal)
      (busy && !conv_tick) |=> busy);

   assert_end_on_tick_R5: assert property (@(posedge clk) disable iff (cal)
      $fell(busy) |-> $past(conv_tick));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (cal)
      !busy |=> $stable(result));

   assert_step_range_R2: assert property (@(posedge clk) disable iff (cal)
      {1'b0, cal_step} < (SW+1)'(N_CORR));

   assert_step_idle_R2: assert property (@(posedge clk) disable iff (cal)
      !busy |-> (cal_step == '0));
endmodule

bind sar_cal_seq sar_cal_seq_chk #(.DW(DW), .N_CORR(N_CORR)) i_chk (
   .clk       (clk),
   .cal       (cal),
   .sample    (sample),
   .conv_tick (conv_tick),
   .busy      (busy),
   .dac_word  (dac_word),
   .result    (result),
   .cal_step  (cal_step)
);

// File: tb/test_sar_cal_seq.sv
`timescale 1ns/1ps
module test_sar_cal_seq;
   localparam int STEP = 8553;
   localparam int CALN = 85530;

   logic        clk = 1'b0;
   logic        cal = 1'b1;
   logic        sample = 1'b0;
   logic        conv_tick = 1'b0;
   logic        comp;
   logic [15:0] cal_meas;
   logic        busy;
   logic [15:0] dac_word, result, trim_word;
   logic [3:0]  cal_step;
   int          vin_code = 0;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #4 clk = ~clk;

   function automatic logic [15:0] meas_of(input int s);
      return 16'h1357 + 16'(s) * 16'h0421;
   endfunction

   function automatic logic [15:0] exp_res(input int x, input bit skip);
      int c;
      if (x < 0) c = 0;
      else if (x > 65535) c = 65535;
      else c = x;
      if (skip && c < 32768) c = 32768;
      return 16'(c) ^ 16'h8000;
   endfunction

   // behavioural analog side
   assign comp     = (vin_code >= int'(dac_word));
   assign cal_meas = meas_of(int'(cal_step));

   sar_cal_seq i_sar_cal_seq (
      .clk(clk), .cal(cal), .sample(sample), .conv_tick(conv_tick), .comp(comp),
      .cal_meas(cal_meas), .busy(busy), .dac_word(dac_word), .result(result),
      .cal_step(cal_step), .trim_word(trim_word)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic run_cal(input bit with_diag);
      conv_tick = 1'b1;
      for (int t = 1; t <= CALN; t++) begin
         cyc();
         if (t == STEP - 1)  check("R2 step before boundary", cal_step, 0);
         if (t == STEP)      check("R2 step after boundary", cal_step, 1);
         if (with_diag && t == 3*STEP + 4) sample = 1'b1;
         if (with_diag && t == 3*STEP + 6) begin
            check("R10 diag bits", result[1:0], 2'd3);
            check("R2 step three", cal_step, 3);
            sample = 1'b0;
         end
         if (with_diag && t == 3*STEP + 8) check("R10 no diag with sample low", result, 16'h0000);
         if (t == CALN - 1) begin
            check("R2 busy before end", busy, 1);
            check("R2 last step", cal_step, 9);
         end
         if (t == CALN) begin
            check("R2 busy falls at end", busy, 0);
            check("R2 step cleared", cal_step, 0);
         end
      end
      conv_tick = 1'b0;
   endtask

   task automatic convert(input int code, input bit skip, input bit hold_next, input bit glitch);
      logic [15:0] prev;
      bit          was_high;
      prev     = result;
      vin_code = code;
      was_high = sample;
      if (!sample) begin
         sample = 1'b1;
         cyc();
      end
      sample = 1'b0;
      cyc();
      check(was_high ? "R9 continuous commit" : "R4 commit busy", busy, 1);
      check("R4 first trial word", dac_word, 16'h8000);
      check("R12 trim before first tick", trim_word, meas_of(1));
      for (int k = 1; k <= 17; k++) begin
         if ($urandom_range(0, 3) == 0) cyc();
         conv_tick = 1'b1;
         cyc();
         conv_tick = 1'b0;
         if (glitch && k == 5) sample = 1'b1;
         if (glitch && k == 6) sample = 1'b0;
         if (hold_next && k == 12) sample = 1'b1;
         if (k == 8) check("R12 trim last corrected bit", trim_word, meas_of(9));
         if (k == 9) check("R12 trim back to offset", trim_word, meas_of(0));
         if (k == 16) begin
            check(glitch ? "R7 busy held despite sample" : "R5 busy before 17th", busy, 1);
            check("R5 result held before 17th", result, prev);
         end
      end
      check("R5 busy after 17th", busy, 0);
      check(skip ? "R11 missing tail result" :
            (glitch ? "R7 result after sample glitch" : "R6 result"),
            result, exp_res(code, skip));
      check("R3 trim offset entry", trim_word, meas_of(0));
   endtask

   initial begin
      repeat (199000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      int seed_dummy;
      logic [15:0] r_hold, d_hold;
      seed_dummy = $urandom(32'd4711);
      repeat (3) cyc();
      check("R1 busy in reset", busy, 1);
      check("R1 result in reset", result, 16'h0000);
      check("R1 step in reset", cal_step, 0);

      cal = 1'b0;
      run_cal(1'b1);
      conv_tick = 1'b1; cyc(); conv_tick = 1'b0;   // trailing tick (R11)

      // directed: clamp and boundary codes (R6)
      convert(70000, 0, 0, 0);
      convert(-3000, 0, 0, 0);
      convert(0, 0, 0, 0);
      convert(65535, 0, 0, 0);
      convert(32768, 0, 0, 0);
      convert(32767, 0, 0, 1);

      // idle ticks ignored (R8)
      r_hold = result;
      d_hold = dac_word;
      for (int i = 0; i < 6; i++) begin
         conv_tick = 1'b1; cyc(); conv_tick = 1'b0;
      end
      check("R8 result after idle ticks", result, r_hold);
      check("R8 dac after idle ticks", dac_word, d_hold);

      // continuous mode (R9)
      convert(12345, 0, 1, 0);
      convert(54321, 0, 0, 0);

      // random conversions
      for (int n = 0; n < 24; n++) begin
         convert(int'($urandom_range(0, 65535)), 0,
                 $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0);
      end
      if (sample) begin
         sample = 1'b0; cyc();
      end

      // abort a conversion (R1)
      vin_code = 1000;
      sample = 1'b1; cyc();
      sample = 1'b0; cyc();
      conv_tick = 1'b1;
      repeat (5) cyc();
      conv_tick = 1'b0;
      cal = 1'b1;
      #1;
      check("R1 busy on abort", busy, 1);
      check("R1 result cleared on abort", result, 16'h0000);
      check("R1 step cleared on abort", cal_step, 0);
      repeat (2) cyc();
      cal = 1'b0;

      // abort calibration (R13)
      conv_tick = 1'b1;
      for (int t = 0; t < 8600; t++) cyc();
      conv_tick = 1'b0;
      check("R13 step advanced before abort", cal_step, 1);
      cal = 1'b1;
      #1;
      check("R13 step restarted", cal_step, 0);
      check("R13 busy held", busy, 1);
      cyc();
      cal = 1'b0;
      run_cal(1'b0);

      // no trailing tick: first conversion loses the MSB decision (R11)
      convert(16'h4321, 1, 0, 0);
      convert(16'h4321, 0, 0, 0);

      summary();
      $finish;
   end
endmodule